// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block watches the outcome of error checking on two memory ports, an internal SRAM port and a flash port. Any uncorrectable error on a qualified access raises a one-cycle exception strobe to the processor core. The enables do not affect this strobe. Each source also has its own reporting enable. When that enable is set, the block records the faulting address, the raw bus data and the access attributes, and sets a sticky status flag for the source. The flags drive an interrupt request whose priority software programs.

SRAM check bits are unknown after power-up. The block therefore tracks, per SRAM word, whether a write has reached that word since reset. An error flagged on a word that has never been written is treated as noise and ignored. Flash contents are always programmed, so flash errors need no such filter. Software reads and writes the control, status, priority and capture registers through a simple register port. Writes are narrow, and reads are combinational.

Top module: `ecc_fault_logger`

## Requirements
- R1: An uncorrectable error on a qualified access from either port drives `core_dexc` high in exactly the cycle after the access, whatever the enables are set to. An access without the uncorrectable flag leaves `core_dexc` low.
- R2: Register 0 is control. Bit 0 enables SRAM reporting and bit 1 enables flash reporting. Both read back as written.
- R3: An uncorrectable error from a source whose reporting enable is clear changes neither the status flags nor the capture registers.
- R4: An enabled event captures the following, all readable from the cycle after the access. Register 3 holds the address. Register 4 holds the data exactly as presented on the port's data bus. Register 5 holds the attributes: bits 1:0 size, bit 2 write flag, bit 3 source (0 SRAM, 1 flash; the flash write flag is always 0).
- R5: A later enabled event overwrites the capture registers, so they always describe the most recent enabled event.
- R6: Register 1 is status. Bit 0 is the SRAM flag and bit 1 is the flash flag. The flags are sticky and cleared by writing 1; writing 0 has no effect. An event in the same cycle as a clear of its flag leaves the flag set.
- R7: Register 2 bits 3:0 hold the interrupt priority, which resets to 0. `irq_prio` shows this value. `irq_req` is high when any status flag is set and the priority is non-zero; it stays low at priority 0.
- R8: An SRAM word not written since reset has uninitialized check bits. An error flagged on an access to such a word causes no exception, no status change and no capture. A write access to a word marks it initialized from the next cycle.
- R9: If enabled SRAM and flash events occur in the same cycle, the SRAM event is captured and both status flags are set.
- R10: After reset, control, status and priority read 0, and `core_dexc` and `irq_req` are low. The capture registers are undefined until the first enabled event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_acc | input | 1 | SRAM access strobe |
| ram_wr | input | 1 | SRAM access is a write |
| ram_size | input | 2 | SRAM access size code |
| ram_addr | input | AW | SRAM byte address |
| ram_data | input | DW | SRAM data bus value |
| ram_uncorr | input | 1 | Uncorrectable error flagged on this SRAM access |
| fl_acc | input | 1 | Flash read strobe |
| fl_size | input | 2 | Flash access size code |
| fl_addr | input | AW | Flash byte address |
| fl_data | input | DW | Flash data bus value |
| fl_uncorr | input | 1 | Uncorrectable error flagged on this flash access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| core_dexc | output | 1 | Data-access exception strobe to the core |
| irq_req | output | 1 | Reporting interrupt request |
| irq_prio | output | 4 | Priority of the reporting interrupt |

## Verification
Every result of an access is registered once. `core_dexc`, the status flags and the capture registers all change at the first rising edge after the access is presented, and `irq_req` follows the flags in that same cycle. The bench drives each access at a falling edge and samples `core_dexc` at the next falling edge, before releasing the inputs. It reads registers only after that edge, since the read port is combinational. Uninitialized-word and same-cycle set/clear cases are checked at that point too.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int REG_W  = 32;
    localparam int PRIO_W = 4;
    localparam int RA_W   = 3;
    localparam int WD_W   = PRIO_W;

    typedef enum logic {
        SRC_RAM   = 1'b0,
        SRC_FLASH = 1'b1
    } src_e;

    typedef enum logic [RA_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_STATUS = 3'd1,
        RA_PRIO   = 3'd2,
        RA_ADDR   = 3'd3,
        RA_DATA   = 3'd4,
        RA_ATTR   = 3'd5,
        RA_RSV6   = 3'd6,
        RA_RSV7   = 3'd7
    } reg_e;

    typedef struct packed {
        src_e       src;
        logic       wr;
        logic [1:0] size;
    } attr_t;

    function automatic logic [REG_W-1:0] attr_word(attr_t a);
        return {{(REG_W-4){1'b0}}, a.src, a.wr, a.size};
    endfunction

endpackage

// File: rtl/ecc_init_tracker.sv
module ecc_init_tracker #(
    parameter int WORDS = 64,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    output logic          init_ok
);
    logic [WORDS-1:0] seen_q;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                seen_q[i] <= 1'b0;
            else if (acc && wr && (idx == IW'(i)))
                seen_q[i] <= 1'b1;
        end
    end

    assign init_ok = seen_q[idx];

    AST_WORD_STAYS_INIT: assert property (@(posedge clk) disable iff (rst)
        (acc && wr) |=> seen_q[$past(idx)]);  // R8

endmodule

// File: rtl/ecc_evt_select.sv
module ecc_evt_select import ecc_log_pkg::*; #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          ram_hit,
    input  logic          ram_wr,
    input  logic [1:0]    ram_size,
    input  logic [AW-1:0] ram_addr,
    input  logic [DW-1:0] ram_data,
    input  logic          fl_hit,
    input  logic [1:0]    fl_size,
    input  logic [AW-1:0] fl_addr,
    input  logic [DW-1:0] fl_data,
    input  logic          en_ram,
    input  logic          en_fl,
    output logic          dexc_d,
    output logic          set_ram,
    output logic          set_fl,
    output logic          cap_v,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data,
    output attr_t         cap_attr
);
    assign dexc_d  = ram_hit | fl_hit;
    assign set_ram = ram_hit & en_ram;
    assign set_fl  = fl_hit & en_fl;
    assign cap_v   = set_ram | set_fl;

    always_comb begin
        if (set_ram) begin
            cap_addr      = ram_addr;
            cap_data      = ram_data;
            cap_attr.src  = SRC_RAM;
            cap_attr.wr   = ram_wr;
            cap_attr.size = ram_size;
        end else begin
            cap_addr      = fl_addr;
            cap_data      = fl_data;
            cap_attr.src  = SRC_FLASH;
            cap_attr.wr   = 1'b0;
            cap_attr.size = fl_size;
        end
    end

endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs import ecc_log_pkg::*; #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WD_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              set_ram,
    input  logic              set_fl,
    input  logic              cap_v,
    input  logic [AW-1:0]     cap_addr,
    input  logic [DW-1:0]     cap_data,
    input  attr_t             cap_attr,
    output logic              en_ram,
    output logic              en_fl,
    output logic              irq_req,
    output logic [PRIO_W-1:0] irq_prio
);
    reg_e              ra;
    logic [1:0]        ctrl_q;
    logic [1:0]        stat_q;
    logic [1:0]        stat_d;
    logic [1:0]        stat_set;
    logic [PRIO_W-1:0] prio_q;
    logic [AW-1:0]     cap_addr_q;
    logic [DW-1:0]     cap_data_q;
    attr_t             cap_attr_q;
    logic              wr_stat;

    assign ra       = reg_e'(reg_addr);
    assign wr_stat  = reg_we && (ra == RA_STATUS);
    assign stat_set = {set_fl, set_ram};

    for (genvar i = 0; i < 2; i++) begin : g_flag
        assign stat_d[i] = stat_set[i] | (stat_q[i] & ~(wr_stat & reg_wdata[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            prio_q <= '0;
        end else begin
            stat_q <= stat_d;
            if (reg_we && (ra == RA_CTRL)) ctrl_q <= reg_wdata[1:0];
            if (reg_we && (ra == RA_PRIO)) prio_q <= reg_wdata;
        end
    end

    // capture registers carry no reset: contents are undefined until the first event
    always_ff @(posedge clk) begin
        if (cap_v) begin
            cap_addr_q <= cap_addr;
            cap_data_q <= cap_data;
            cap_attr_q <= cap_attr;
        end
    end

    always_comb begin
        unique case (ra)
            RA_CTRL:   reg_rdata = REG_W'(ctrl_q);
            RA_STATUS: reg_rdata = REG_W'(stat_q);
            RA_PRIO:   reg_rdata = REG_W'(prio_q);
            RA_ADDR:   reg_rdata = REG_W'(cap_addr_q);
            RA_DATA:   reg_rdata = REG_W'(cap_data_q);
            RA_ATTR:   reg_rdata = attr_word(cap_attr_q);
            default:   reg_rdata = '0;
        endcase
    end

    assign en_ram   = ctrl_q[0];
    assign en_fl    = ctrl_q[1];
    assign irq_prio = prio_q;
    assign irq_req  = (|stat_q) && (prio_q != '0);

    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cap_v |=> ($stable(cap_addr_q) && $stable(cap_data_q)));  // R3
    AST_RAM_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_q[0] && !(wr_stat && reg_wdata[0])) |=> stat_q[0]);  // R6
    AST_FLASH_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_q[1] && !(wr_stat && reg_wdata[1])) |=> stat_q[1]);  // R6
    AST_RAM_WINS_TIE: assert property (@(posedge clk) disable iff (rst)
        (set_ram && set_fl) |=> (cap_attr_q.src == SRC_RAM && stat_q == 2'b11));  // R9

endmodule

// File: rtl/ecc_fault_logger.sv
module ecc_fault_logger import ecc_log_pkg::*; #(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int RAM_WORDS = 64,
    localparam int IW       = $clog2(RAM_WORDS),
    localparam int BOFF     = $clog2(DW/8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ram_acc,
    input  logic              ram_wr,
    input  logic [1:0]        ram_size,
    input  logic [AW-1:0]     ram_addr,
    input  logic [DW-1:0]     ram_data,
    input  logic              ram_uncorr,
    input  logic              fl_acc,
    input  logic [1:0]        fl_size,
    input  logic [AW-1:0]     fl_addr,
    input  logic [DW-1:0]     fl_data,
    input  logic              fl_uncorr,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WD_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              core_dexc,
    output logic              irq_req,
    output logic [PRIO_W-1:0] irq_prio
);
    logic          ram_init_ok;
    logic          ram_hit, fl_hit;
    logic          en_ram, en_fl;
    logic          dexc_d;
    logic          set_ram, set_fl, cap_v;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    attr_t         cap_attr;
    logic          dexc_q;

    ecc_init_tracker #(.WORDS(RAM_WORDS)) u_init (
        .clk     (clk),
        .rst     (rst),
        .acc     (ram_acc),
        .wr      (ram_wr),
        .idx     (ram_addr[BOFF +: IW]),
        .init_ok (ram_init_ok)
    );

    assign ram_hit = ram_acc & ram_uncorr & ram_init_ok;
    assign fl_hit  = fl_acc & fl_uncorr;

    ecc_evt_select #(.AW(AW), .DW(DW)) u_sel (
        .ram_hit  (ram_hit),
        .ram_wr   (ram_wr),
        .ram_size (ram_size),
        .ram_addr (ram_addr),
        .ram_data (ram_data),
        .fl_hit   (fl_hit),
        .fl_size  (fl_size),
        .fl_addr  (fl_addr),
        .fl_data  (fl_data),
        .en_ram   (en_ram),
        .en_fl    (en_fl),
        .dexc_d   (dexc_d),
        .set_ram  (set_ram),
        .set_fl   (set_fl),
        .cap_v    (cap_v),
        .cap_addr (cap_addr),
        .cap_data (cap_data),
        .cap_attr (cap_attr)
    );

    ecc_log_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_ram   (set_ram),
        .set_fl    (set_fl),
        .cap_v     (cap_v),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .cap_attr  (cap_attr),
        .en_ram    (en_ram),
        .en_fl     (en_fl),
        .irq_req   (irq_req),
        .irq_prio  (irq_prio)
    );

    always_ff @(posedge clk) begin
        if (rst) dexc_q <= 1'b0;
        else     dexc_q <= dexc_d;
    end

    assign core_dexc = dexc_q;

    AST_FLASH_ERR_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (fl_acc && fl_uncorr) |=> core_dexc);  // R1
    AST_NO_ERR_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        (!(ram_acc && ram_uncorr) && !(fl_acc && fl_uncorr)) |=> !core_dexc);  // R1
    AST_UNINIT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ram_acc && ram_uncorr && !ram_init_ok && !(fl_acc && fl_uncorr)) |=> !core_dexc);  // R8
    AST_PRIO_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_prio != '0));  // R7

endmodule

// File: tb/ecc_fault_logger_tb.sv
module ecc_fault_logger_tb;
    import ecc_log_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NROW = 9;
    // row: [7:6] enables {flash,ram}, [5] ram err, [4] flash err,
    //      [3] expected exception, [2:1] expected status, [0] expected source
    localparam logic [7:0] TBL [NROW] = '{
        8'b00101000, 8'b00011000, 8'b01101010, 8'b01011000, 8'b10011101,
        8'b10101000, 8'b11111110, 8'b11000000, 8'b10111101
    };

    logic clk = 1'b0, rst = 1'b1;
    logic ram_acc = 0, ram_wr = 0, ram_uncorr = 0;
    logic [1:0] ram_size = 0;
    logic [15:0] ram_addr = 0;
    logic [31:0] ram_data = 0;
    logic fl_acc = 0, fl_uncorr = 0;
    logic [1:0] fl_size = 0;
    logic [15:0] fl_addr = 0;
    logic [31:0] fl_data = 0;
    logic reg_we = 0;
    logic [2:0] reg_addr = 0;
    logic [3:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic core_dexc, irq_req;
    logic [3:0] irq_prio;

    int n_chk = 0, n_err = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_fault_logger u_dut (
        .clk(clk), .rst(rst),
        .ram_acc(ram_acc), .ram_wr(ram_wr), .ram_size(ram_size), .ram_addr(ram_addr),
        .ram_data(ram_data), .ram_uncorr(ram_uncorr),
        .fl_acc(fl_acc), .fl_size(fl_size), .fl_addr(fl_addr), .fl_data(fl_data),
        .fl_uncorr(fl_uncorr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_dexc(core_dexc), .irq_req(irq_req), .irq_prio(irq_prio)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic evt(input logic ra, input logic rw, input logic ru, input logic [15:0] radr,
                       input logic [31:0] rdat, input logic [1:0] rsz,
                       input logic fa, input logic fu, input logic [15:0] fadr,
                       input logic [31:0] fdat, input logic [1:0] fsz, output logic dexc);
        ram_acc = ra; ram_wr = rw; ram_uncorr = ru; ram_addr = radr; ram_data = rdat; ram_size = rsz;
        fl_acc = fa; fl_uncorr = fu; fl_addr = fadr; fl_data = fdat; fl_size = fsz;
        @(negedge clk);
        dexc = core_dexc;
        ram_acc = 0; ram_wr = 0; ram_uncorr = 0; fl_acc = 0; fl_uncorr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic dx;
        logic [7:0] row;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10 reset state
        rd(3'd0, d); chk("R10 ctrl", d, 0);
        rd(3'd1, d); chk("R10 status", d, 0);
        rd(3'd2, d); chk("R10 prio", d, 0);
        chk("R10 dexc", {31'b0, core_dexc}, 0);
        chk("R10 irq", {31'b0, irq_req}, 0);

        // R8 first: error on a word never written is ignored
        wr(3'd0, 4'd3);
        evt(1, 0, 1, 16'd160, 32'h1234_5678, 2'd2, 0, 0, 0, 0, 0, dx);
        chk("R8 uninit dexc", {31'b0, dx}, 0);
        rd(3'd1, d); chk("R8 uninit status", d, 0);
        evt(1, 1, 0, 16'd160, 32'h0, 2'd2, 0, 0, 0, 0, 0, dx);
        evt(1, 0, 1, 16'd160, 32'hCAFE_0001, 2'd2, 0, 0, 0, 0, 0, dx);
        chk("R8 inited dexc", {31'b0, dx}, 1);
        rd(3'd1, d); chk("R8 inited status", d, 1);
        rd(3'd3, d); chk("R8 inited addr", d, 160);

        // R2 control readback
        wr(3'd0, 4'd2); rd(3'd0, d); chk("R2 ctrl=2", d, 2);
        wr(3'd0, 4'd1); rd(3'd0, d); chk("R2 ctrl=1", d, 1);

        // initialise words 0..15
        for (int i = 0; i < 16; i++) evt(1, 1, 0, 16'(i*4), 0, 2'd2, 0, 0, 0, 0, 0, dx);

        // table walk: R1 R3 R4 R9
        for (int k = 0; k < NROW; k++) begin
            row = TBL[k];
            wr(3'd0, {2'b0, row[7:6]});
            wr(3'd1, 4'b0011);
            evt(1, 0, row[5], 16'(k*4), 32'hA000_0000 + k, 2'd2,
                1, row[4], 16'h8000 + 16'(k), 32'hF000_0000 + k, 2'd1, dx);
            chk($sformatf("R1 row%0d dexc", k), {31'b0, dx}, {31'b0, row[3]});
            rd(3'd1, d); chk($sformatf("R3 R9 row%0d status", k), d, {30'b0, row[2:1]});
            if (row[2:1] != 2'b00) begin
                rd(3'd5, d);
                chk($sformatf("R4 row%0d attr", k), d, row[0] ? 32'h9 : 32'h2);
                rd(3'd3, d);
                chk($sformatf("R4 row%0d addr", k), d, row[0] ? 32'h8000 + k : 32'(k*4));
                rd(3'd4, d);
                chk($sformatf("R4 row%0d data", k), d, row[0] ? 32'hF000_0000 + k : 32'hA000_0000 + k);
            end
        end

        // R4 write flag on a write access with error
        wr(3'd0, 4'd3); wr(3'd1, 4'd3);
        evt(1, 1, 1, 16'd8, 32'h5555_AAAA, 2'd1, 0, 0, 0, 0, 0, dx);
        rd(3'd5, d); chk("R4 write attr", d, 32'h5);
        rd(3'd4, d); chk("R4 raw data", d, 32'h5555_AAAA);

        // R5 overwrite by later events
        evt(1, 0, 1, 16'd12, 32'h1111_0000, 2'd0, 0, 0, 0, 0, 0, dx);
        rd(3'd3, d); chk("R5 second addr", d, 12);
        evt(0, 0, 0, 0, 0, 0, 1, 1, 16'h9ABC, 32'h2222_0000, 2'd3, dx);
        rd(3'd3, d); chk("R5 flash addr", d, 32'h9ABC);
        rd(3'd5, d); chk("R5 flash attr", d, 32'hB);

        // R3 disabled source leaves capture alone
        wr(3'd0, 4'd0); wr(3'd1, 4'd3);
        evt(1, 0, 1, 16'd20, 32'h7777_7777, 2'd2, 1, 1, 16'h1, 32'h1, 2'd0, dx);
        chk("R3 dexc still", {31'b0, dx}, 1);
        rd(3'd3, d); chk("R3 addr kept", d, 32'h9ABC);
        rd(3'd1, d); chk("R3 status kept", d, 0);

        // R6 sticky, write-0 no effect, partial clear, set beats clear
        wr(3'd0, 4'd3);
        evt(1, 0, 1, 16'd4, 0, 2'd2, 1, 1, 16'h2, 0, 2'd0, dx);
        wr(3'd1, 4'd0); rd(3'd1, d); chk("R6 write0", d, 3);
        wr(3'd1, 4'd1); rd(3'd1, d); chk("R6 clear ram only", d, 2);
        wr(3'd1, 4'd2);
        evt(1, 0, 1, 16'd4, 0, 2'd2, 0, 0, 0, 0, 0, dx);
        reg_we = 1; reg_addr = 3'd1; reg_wdata = 4'd1;
        ram_acc = 1; ram_uncorr = 1; ram_addr = 16'd4;
        @(negedge clk);
        reg_we = 0; ram_acc = 0; ram_uncorr = 0;
        rd(3'd1, d); chk("R6 set beats clear", d, 1);

        // R7 priority gating
        chk("R7 prio0 irq", {31'b0, irq_req}, 0);
        wr(3'd2, 4'd5);
        chk("R7 prio5 irq", {31'b0, irq_req}, 1);
        chk("R7 irq_prio", {28'b0, irq_prio}, 5);
        wr(3'd1, 4'd3);
        chk("R7 cleared irq", {31'b0, irq_req}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule